// File: doc/BRIEF.md
# Array Descriptor and Index Checker

This block carries out the array-handling operations of a tagged-word stack machine. Each data word is 64 bits wide and has a 4-bit type tag beside it. An array is reached through a descriptor word. The descriptor packs the element count and the byte address of the first element, and it carries its own tag. The block builds descriptors from the live stack pointer and sets aside room for array bodies at run time. It turns an element number into a checked element address, and it reads the element count back out of a descriptor. It also handles the plain stack-pointer bumps used for scalar allocation.

The surrounding core pops the operands and presents them to the block with their tags, together with the current stack pointer, and raises a one-cycle operation strobe. One clock later the block drives its results as one-cycle pulses: a value to push, a memory write request, a stack-pointer load, or a trap. When an array is created, the block then clears the new body. It issues one write per cycle that marks each body word as undefined, and it holds `busy` high while this runs. New operations offered while `busy` is high are dropped.

Top module: `arr_desc_unit`

## Requirements
- R1: After reset, pushValid, memWe, spLoad, trap and busy are all low.
- R2: ARRAY (opCode 1, opA = element count tagged INTG (1), opB = destination tagged ADDR (4)) produces, one cycle after the strobe, a memory write to opB[31:0]. The write data is {count[31:0], spIn} (count in bits 63:32, start address in bits 31:0) and the write tag is DESC (5). In the same cycle the block drives spLoad with spNext = spIn + 8*count.
- R3: After an ARRAY with a count N greater than 0, the next N cycles each carry one write. The writes go to spIn, spIn+8, and so on, with data 0 and tag UNDF (0). busy is high from the cycle after the strobe until the last of these writes is on the outputs. A count of 0 issues no body writes and leaves busy low.
- R4: ARRAY traps, and makes no write and no SP load, when opA is not tagged INTG, when opA is negative or 2^32 or larger, or when opB is not tagged ADDR.
- R5: INDEX (opCode 2, opA = element number, opB = descriptor) pushes start + 8*index, zero-extended to 64 bits and tagged ADDR, when 0 <= index < count.
- R6: INDEX traps when the element number is negative or is not less than the count held in the descriptor.
- R7: INDEX traps when opB is not tagged DESC or opA is not tagged INTG.
- R8: SIZE (opCode 3, opA = descriptor) pushes the count field zero-extended and tagged INTG. It traps when opA is not tagged DESC.
- R9: ALLOC (opCode 4, opA = word count tagged INTG, below 2^32) loads spNext = spIn + 8*count, and traps otherwise. STEP (opCode 5) loads spNext = spIn + 8.
- R10: A strobe raised while busy is high has no effect: it produces no push, no trap and no SP load, and the body clearing goes on unchanged.
- R11: In a cycle with trap high, pushValid, memWe and spLoad are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | One-cycle operation strobe |
| opCode | input | 3 | 0 none, 1 ARRAY, 2 INDEX, 3 SIZE, 4 ALLOC, 5 STEP |
| opAVal | input | 64 | First popped operand value |
| opATag | input | 4 | First popped operand tag |
| opBVal | input | 64 | Second popped operand value |
| opBTag | input | 4 | Second popped operand tag |
| spIn | input | 32 | Current stack pointer (byte address) |
| pushValid | output | 1 | Push the result value |
| pushVal | output | 64 | Value to push |
| pushTag | output | 4 | Tag of the pushed value |
| memWe | output | 1 | Memory write request |
| memAddr | output | 32 | Write byte address |
| memData | output | 64 | Write data |
| memTag | output | 4 | Write tag |
| spLoad | output | 1 | Load the stack pointer |
| spNext | output | 32 | New stack pointer |
| trap | output | 1 | Operation faulted |
| busy | output | 1 | Body clearing in progress |

## Verification
The bench builds the block with its default 64-bit words, 32-bit addresses and 4-bit tags. At these widths the count and start fields of a descriptor sit apart, so a swapped half shows up in the checks. Body sizes stay small, from 0 to 4 words, which is enough to see the first and last clearing writes, the stride between them and the moment busy drops. The element numbers used are -1, 0, size-1 and size, so both bounds checks are reached. A 2^32 count is also applied to reach the range check on ARRAY.

// File: rtl/arr_desc_pkg.sv
package arr_desc_pkg;
  localparam int TAG_W = 4;

  typedef enum logic [TAG_W-1:0] {
    TAG_UNDF = 4'd0,
    TAG_INTG = 4'd1,
    TAG_FLOT = 4'd2,
    TAG_BOOL = 4'd3,
    TAG_ADDR = 4'd4,
    TAG_DESC = 4'd5
  } tag_e;

  typedef enum logic [2:0] {
    OP_NONE  = 3'd0,
    OP_ARRAY = 3'd1,
    OP_INDEX = 3'd2,
    OP_SIZE  = 3'd3,
    OP_ALLOC = 3'd4,
    OP_STEP  = 3'd5
  } op_e;

  // strobes from control to datapath
  typedef struct packed {
    logic captureOp;
    logic fillLoad;
    logic fillWrite;
  } ctl_s;
endpackage

// File: rtl/arr_desc_ctrl.sv
module arr_desc_ctrl
  import arr_desc_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic opValid,
  input  logic fillNeed,
  input  logic lastFill,
  output ctl_s ctl,
  output logic busy
);
  typedef enum logic { ST_IDLE, ST_FILL } state_e;
  state_e state, stateNext;

  always_comb begin
    ctl = '0;
    stateNext = state;
    if (state == ST_IDLE) begin
      ctl.captureOp = opValid;
      if (opValid && fillNeed) begin
        ctl.fillLoad = 1'b1;
        stateNext = ST_FILL;
      end
    end else begin
      ctl.fillWrite = 1'b1;
      if (lastFill) stateNext = ST_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign busy = (state == ST_FILL);

  // R10
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !ctl.captureOp && !ctl.fillLoad);

  // R3
  fill_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.fillLoad |=> busy);
endmodule

// File: rtl/arr_desc_dp.sv
module arr_desc_dp
  import arr_desc_pkg::*;
#(
  parameter int WORD_W = 64,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctl_s              ctl,
  input  logic [2:0]        opCode,
  input  logic [WORD_W-1:0] opAVal,
  input  logic [TAG_W-1:0]  opATag,
  input  logic [WORD_W-1:0] opBVal,
  input  logic [TAG_W-1:0]  opBTag,
  input  logic [ADDR_W-1:0] spIn,
  output logic              fillNeed,
  output logic              lastFill,
  output logic              pushValid,
  output logic [WORD_W-1:0] pushVal,
  output logic [TAG_W-1:0]  pushTag,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [WORD_W-1:0] memData,
  output logic [TAG_W-1:0]  memTag,
  output logic              spLoad,
  output logic [ADDR_W-1:0] spNext,
  output logic              trap
);
  localparam int HI_W    = WORD_W - ADDR_W;
  localparam int WORD_BY = 8;

  // fields of operands
  logic [ADDR_W-1:0] aLow, bSize, bStart;
  logic              aFits, aNeg;
  logic [WORD_W-1:0] idxLimit;
  assign aLow   = opAVal[ADDR_W-1:0];
  assign aFits  = (opAVal[WORD_W-1:ADDR_W] == '0);
  assign aNeg   = opAVal[WORD_W-1];
  assign bSize  = opBVal[WORD_W-1:HI_W];
  assign bStart = opBVal[ADDR_W-1:0];
  assign idxLimit = {{HI_W{1'b0}}, bSize};

  // combinational result of the presented op
  logic              rPush, rMem, rSp, rTrap;
  logic [WORD_W-1:0] rPushVal, rMemData;
  logic [TAG_W-1:0]  rPushTag;
  logic [ADDR_W-1:0] rMemAddr, rSpNext;

  always_comb begin
    rPush = 1'b0; rMem = 1'b0; rSp = 1'b0; rTrap = 1'b0;
    rPushVal = '0; rPushTag = TAG_UNDF; rMemData = '0;
    rMemAddr = '0; rSpNext = spIn;
    fillNeed = 1'b0;
    unique case (op_e'(opCode))
      OP_ARRAY: begin
        if (opATag != TAG_INTG || !aFits || opBTag != TAG_ADDR) rTrap = 1'b1;
        else begin
          rMem     = 1'b1;
          rMemAddr = bStart;
          rMemData = {aLow, spIn};
          rSp      = 1'b1;
          rSpNext  = spIn + aLow * WORD_BY;
          fillNeed = (aLow != '0);
        end
      end
      OP_INDEX: begin
        if (opBTag != TAG_DESC || opATag != TAG_INTG || aNeg || opAVal >= idxLimit)
          rTrap = 1'b1;
        else begin
          rPush    = 1'b1;
          rPushTag = TAG_ADDR;
          rPushVal = {{HI_W{1'b0}}, bStart + aLow * WORD_BY};
        end
      end
      OP_SIZE: begin
        if (opATag != TAG_DESC) rTrap = 1'b1;
        else begin
          rPush    = 1'b1;
          rPushTag = TAG_INTG;
          rPushVal = {{HI_W{1'b0}}, opAVal[WORD_W-1:HI_W]};
        end
      end
      OP_ALLOC: begin
        if (opATag != TAG_INTG || !aFits) rTrap = 1'b1;
        else begin
          rSp     = 1'b1;
          rSpNext = spIn + aLow * WORD_BY;
        end
      end
      OP_STEP: begin
        rSp     = 1'b1;
        rSpNext = spIn + ADDR_W'(WORD_BY);
      end
      default: ;
    endcase
  end

  // body clearing state
  logic [ADDR_W-1:0] fillAddr, fillLeft;
  assign lastFill = (fillLeft == ADDR_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fillAddr <= '0;
      fillLeft <= '0;
    end else if (ctl.fillLoad) begin
      fillAddr <= spIn;
      fillLeft <= aLow;
    end else if (ctl.fillWrite) begin
      fillAddr <= fillAddr + ADDR_W'(WORD_BY);
      fillLeft <= fillLeft - 1'b1;
    end
  end

  // registered outputs
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pushValid <= 1'b0; memWe <= 1'b0; spLoad <= 1'b0; trap <= 1'b0;
      pushVal <= '0; pushTag <= TAG_UNDF; memAddr <= '0; memData <= '0;
      memTag <= TAG_UNDF; spNext <= '0;
    end else if (ctl.captureOp) begin
      pushValid <= rPush; pushVal <= rPushVal; pushTag <= rPushTag;
      memWe <= rMem; memAddr <= rMemAddr; memData <= rMemData; memTag <= TAG_DESC;
      spLoad <= rSp; spNext <= rSpNext; trap <= rTrap;
    end else if (ctl.fillWrite) begin
      pushValid <= 1'b0; spLoad <= 1'b0; trap <= 1'b0;
      memWe <= 1'b1; memAddr <= fillAddr; memData <= '0; memTag <= TAG_UNDF;
    end else begin
      pushValid <= 1'b0; memWe <= 1'b0; spLoad <= 1'b0; trap <= 1'b0;
    end
  end

  // R11
  trap_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    trap |-> !pushValid && !memWe && !spLoad);

  // R5
  index_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pushValid && pushTag == TAG_ADDR) |-> pushVal[WORD_W-1:ADDR_W] == '0);

  // R3
  fill_stride_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memWe && memTag == TAG_UNDF && $past(memWe && memTag == TAG_UNDF))
      |-> memAddr == $past(memAddr) + ADDR_W'(WORD_BY));

  // R3
  fill_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memWe && memTag == TAG_UNDF) |-> memData == '0 && !pushValid);
endmodule

// File: rtl/arr_desc_unit.sv
module arr_desc_unit
  import arr_desc_pkg::*;
#(
  parameter int WORD_W = 64,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [2:0]        opCode,
  input  logic [WORD_W-1:0] opAVal,
  input  logic [3:0]        opATag,
  input  logic [WORD_W-1:0] opBVal,
  input  logic [3:0]        opBTag,
  input  logic [ADDR_W-1:0] spIn,
  output logic              pushValid,
  output logic [WORD_W-1:0] pushVal,
  output logic [3:0]        pushTag,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [WORD_W-1:0] memData,
  output logic [3:0]        memTag,
  output logic              spLoad,
  output logic [ADDR_W-1:0] spNext,
  output logic              trap,
  output logic              busy
);
  ctl_s ctl;
  logic fillNeed, lastFill;

  arr_desc_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .opValid(opValid), .fillNeed(fillNeed),
    .lastFill(lastFill), .ctl(ctl), .busy(busy)
  );

  arr_desc_dp #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) dp_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .opCode(opCode),
    .opAVal(opAVal), .opATag(opATag), .opBVal(opBVal), .opBTag(opBTag),
    .spIn(spIn), .fillNeed(fillNeed), .lastFill(lastFill),
    .pushValid(pushValid), .pushVal(pushVal), .pushTag(pushTag),
    .memWe(memWe), .memAddr(memAddr), .memData(memData), .memTag(memTag),
    .spLoad(spLoad), .spNext(spNext), .trap(trap)
  );
endmodule

// File: tb/arr_desc_unit_tb_top.sv
module arr_desc_unit_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic opValid = 1'b0;
  logic [2:0] opCode = '0;
  logic [63:0] opAVal = '0, opBVal = '0;
  logic [3:0] opATag = '0, opBTag = '0;
  logic [31:0] spIn = '0;
  logic pushValid, memWe, spLoad, trap, busy;
  logic [63:0] pushVal, memData;
  logic [3:0] pushTag, memTag;
  logic [31:0] memAddr, spNext;
  int nRun = 0, nFail = 0;

  always #5 clk = ~clk;

  arr_desc_unit dut_i (.*);

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive at negedge, leaves the sampling point at the next negedge
  task automatic issue(input logic [2:0] op, input logic [63:0] a, input logic [3:0] at,
                       input logic [63:0] b, input logic [3:0] bt, input logic [31:0] sp);
    opValid = 1'b1; opCode = op; opAVal = a; opATag = at; opBVal = b; opBTag = bt; spIn = sp;
    @(negedge clk);
    opValid = 1'b0;
  endtask

  task automatic checkTrapped(input string req);
    chk(trap === 1'b1, req, {63'd0, trap}, 64'd1);
    chk(!pushValid && !memWe && !spLoad, "R11", {61'd0, pushValid, memWe, spLoad}, 64'd0);
  endtask

  task automatic checkFill(input logic [31:0] base, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      chk(memWe && memTag == 4'd0 && memData == 64'd0 && memAddr == base + 32'(8*k),
          "R3", {32'd0, memAddr}, {32'd0, base + 32'(8*k)});
      chk(busy == (k < n-1), "R3", {63'd0, busy}, {63'd0, (k < n-1)});
    end
  endtask

  task automatic tReset();
    chk(!pushValid && !memWe && !spLoad && !trap && !busy, "R1",
        {59'd0, pushValid, memWe, spLoad, trap, busy}, 64'd0);
  endtask

  task automatic tArray(input logic [31:0] sp, input logic [31:0] n, input logic [31:0] dst);
    issue(3'd1, {32'd0, n}, 4'd1, {32'd0, dst}, 4'd4, sp);
    chk(memWe && memTag == 4'd5 && memAddr == dst && memData == {n, sp}, "R2", memData, {n, sp});
    chk(spLoad && spNext == sp + n*8, "R2", {32'd0, spNext}, {32'd0, sp + n*8});
    chk(busy == (n != 0), "R3", {63'd0, busy}, {63'd0, (n != 0)});
    checkFill(sp, int'(n));
    if (n == 0) begin
      @(negedge clk);
      chk(!memWe && !busy, "R3", {62'd0, memWe, busy}, 64'd0);
    end
  endtask

  task automatic tArrayTraps();
    issue(3'd1, 64'd4, 4'd1, 64'h100, 4'd1, 32'h200);
    checkTrapped("R4");
    issue(3'd1, -64'sd2, 4'd1, 64'h100, 4'd4, 32'h200);
    checkTrapped("R4");
    issue(3'd1, 64'h1_0000_0000, 4'd1, 64'h100, 4'd4, 32'h200);
    checkTrapped("R4");
    issue(3'd1, 64'd4, 4'd2, 64'h100, 4'd4, 32'h200);
    checkTrapped("R4");
    @(negedge clk);
    chk(!busy && !memWe, "R4", {62'd0, busy, memWe}, 64'd0);
  endtask

  task automatic tIndex();
    logic [63:0] d = {32'd10, 32'h0000_4000};
    issue(3'd2, 64'd0, 4'd1, d, 4'd5, 32'h0);
    chk(pushValid && pushTag == 4'd4 && pushVal == 64'h4000, "R5", pushVal, 64'h4000);
    issue(3'd2, 64'd9, 4'd1, d, 4'd5, 32'h0);
    chk(pushValid && pushTag == 4'd4 && pushVal == 64'h4048, "R5", pushVal, 64'h4048);
    chk(!spLoad && !memWe, "R5", {62'd0, spLoad, memWe}, 64'd0);
    issue(3'd2, 64'd10, 4'd1, d, 4'd5, 32'h0);
    checkTrapped("R6");
    issue(3'd2, -64'sd1, 4'd1, d, 4'd5, 32'h0);
    checkTrapped("R6");
    issue(3'd2, 64'd1, 4'd1, d, 4'd4, 32'h0);
    checkTrapped("R7");
    issue(3'd2, 64'd1, 4'd2, d, 4'd5, 32'h0);
    checkTrapped("R7");
  endtask

  task automatic tSize();
    issue(3'd3, {32'd77, 32'h1234}, 4'd5, 64'd0, 4'd0, 32'h0);
    chk(pushValid && pushTag == 4'd1 && pushVal == 64'd77, "R8", pushVal, 64'd77);
    issue(3'd3, {32'd77, 32'h1234}, 4'd4, 64'd0, 4'd0, 32'h0);
    checkTrapped("R8");
  endtask

  task automatic tAlloc();
    issue(3'd4, 64'd3, 4'd1, 64'd0, 4'd0, 32'h1000);
    chk(spLoad && spNext == 32'h1018 && !memWe && !pushValid, "R9", {32'd0, spNext}, 64'h1018);
    issue(3'd5, 64'd0, 4'd0, 64'd0, 4'd0, 32'h1018);
    chk(spLoad && spNext == 32'h1020, "R9", {32'd0, spNext}, 64'h1020);
    issue(3'd4, 64'd3, 4'd2, 64'd0, 4'd0, 32'h1000);
    checkTrapped("R9");
  endtask

  task automatic tBusyIgnore();
    issue(3'd1, 64'd3, 4'd1, 64'h80, 4'd4, 32'h3000);
    chk(memWe && memTag == 4'd5, "R10", {60'd0, memTag}, 64'd5);
    // offer a trapping op and an SP op while busy
    issue(3'd2, 64'd99, 4'd1, 64'd0, 4'd5, 32'h0);
    chk(!trap && !pushValid && memTag == 4'd0 && memAddr == 32'h3000, "R10",
        {32'd0, memAddr}, 64'h3000);
    issue(3'd5, 64'd0, 4'd0, 64'd0, 4'd0, 32'h0);
    chk(!spLoad && memAddr == 32'h3008, "R10", {32'd0, memAddr}, 64'h3008);
    @(negedge clk);
    chk(memWe && memAddr == 32'h3010 && !busy, "R10", {32'd0, memAddr}, 64'h3010);
    @(negedge clk);
    chk(!memWe && !spLoad, "R10", {62'd0, memWe, spLoad}, 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    tReset();
    tArray(32'h2000, 32'd3, 32'h40);
    tArray(32'h2100, 32'd0, 32'h48);
    tArray(32'h2200, 32'd1, 32'h50);
    tArrayTraps();
    tIndex();
    tSize();
    tAlloc();
    tBusyIgnore();
    @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nRun++; nFail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule